// File: doc/BRIEF.md
# Interrupt Return State Restorer

This unit executes the machine-state half of the three return-from-interrupt style operations in a 64-bit core: the ordinary interrupt return, the hypervisor interrupt return and the return from a vectored system call. It holds the 64-bit machine state register. When the pipeline commits one of these operations, it raises a commit strobe together with a two-bit kind code and the current values of the save/restore, count and link registers. On that clock edge the unit merges the selected source into the machine state. Each field follows its own rule. Some are copied, some are OR-folded, one field is updated only under a guard, and a privilege bit can only be cleared. In the next cycle it presents the word-aligned resume address with a one-cycle valid pulse.

Bits are numbered big-endian throughout: architectural bit k of any 64-bit register is port bit 63-k. Decode and privilege checks happen upstream, so the kind code arrives already resolved.

The sequencer has two states. In `ST_IDLE` the valid output is low. The transition `commit` (strobe high with a legal kind) moves it to `ST_ISSUE`, where the valid output is high. From `ST_ISSUE` it moves back to `ST_IDLE` when no further legal commit is present, or stays in `ST_ISSUE` on a back-to-back commit.

Top module: `msr_restore_unit`

## Requirements
- R1: While reset is active and after its release, the state output equals the `RESET_MSR` parameter and the valid output is low.
- R2: A legal commit in cycle n raises the valid output in cycle n+1 only. In a cycle without a commit the state output does not change.
- R3: The kind code is 0 = ordinary return, 1 = hypervisor return, 2 = vectored-call return. A commit with code 3 changes neither the state nor the valid output, which stays low.
- R4: State bits 29..31 take the source bits 29..31 unless the current field is 0b010 and the source field is 0b000; in that case they keep the current value.
- R5: For the ordinary and hypervisor returns, state bits 48, 58 and 59 each become the OR of the same source bit and source bit 49.
- R6: For the vectored-call return, state bits 48, 58 and 59 all become source bit 49.
- R7: For the ordinary return, new bit 3 is old bit 3 AND source bit 3. New bit 51 is source bit 51 when old bit 3 is 1, and old bit 51 otherwise. The vectored-call return leaves bits 3 and 51 unchanged.
- R8: The hypervisor return copies source bits 0..28 and 49..57. The other two returns copy bits 0..2, 4..28, 49..50 and 52..57.
- R9: All three returns copy source bits 32, 37..41 and 60..63.
- R10: State bits 33..36 and 42..47 never change after reset.
- R11: The resume address is source bits 0..61 followed by two zero bits. The source is save/restore register 0 for the ordinary return, hypervisor save/restore register 0 for the hypervisor return, and the link register for the vectored-call return. The address appears in the same cycle as the valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | Commit strobe for a return operation |
| kind_i | input | 2 | Return kind code (see R3) |
| srr0_i | input | 64 | Save/restore register 0 (ordinary return address) |
| srr1_i | input | 64 | Save/restore register 1 (ordinary return state) |
| hsrr0_i | input | 64 | Hypervisor save/restore register 0 |
| hsrr1_i | input | 64 | Hypervisor save/restore register 1 |
| ctr_i | input | 64 | Count register (vectored-call return state) |
| lr_i | input | 64 | Link register (vectored-call return address) |
| msr_o | output | 64 | Current machine state |
| nia_o | output | 64 | Resume instruction address |
| nia_valid_o | output | 1 | One-cycle pulse qualifying `nia_o` |

## Verification
The machine state is visible at the ports in every cycle. A wrong merge therefore shows in the cycle after the faulty commit, as a mismatch against a bench model that uses bit masks. A wrong state is also carried into later results, because bit 3, bit 51 and the guarded field depend on the previous value. A sequencer fault shows as a missing, late or stretched valid pulse one cycle after the commit. The stimulus steers the source's guarded field to 0b000 often, so that the guard and bit-3 paths are exercised after random hypervisor loads.

// File: rtl/msr_rest_pkg.sv
package msr_rest_pkg;
    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        RK_NORMAL = 2'd0,
        RK_HYPER  = 2'd1,
        RK_VECTOR = 2'd2,
        RK_NONE   = 2'd3
    } ret_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    // port index of architectural (big-endian) bit k
    function automatic int be(input int k);
        return XLEN - 1 - k;
    endfunction

    // guarded field, architectural bits 29..31
    localparam int TF_HI = XLEN - 1 - 29;
    localparam int TF_LO = XLEN - 1 - 31;
endpackage

// File: rtl/msr_src_select.sv
module msr_src_select
    import msr_rest_pkg::*;
(
    input  ret_kind_e         kind,
    input  logic [XLEN-1:0]   srr0,
    input  logic [XLEN-1:0]   srr1,
    input  logic [XLEN-1:0]   hsrr0,
    input  logic [XLEN-1:0]   hsrr1,
    input  logic [XLEN-1:0]   ctr,
    input  logic [XLEN-1:0]   lr,
    output logic [XLEN-1:0]   state_src,
    output logic [XLEN-1:0]   addr_src
);
    always_comb begin
        unique case (kind)
            RK_NORMAL: begin state_src = srr1;  addr_src = srr0;  end
            RK_HYPER:  begin state_src = hsrr1; addr_src = hsrr0; end
            RK_VECTOR: begin state_src = ctr;   addr_src = lr;    end
            default:   begin state_src = '0;    addr_src = '0;    end
        endcase
    end
endmodule

// File: rtl/msr_field_merge.sv
module msr_field_merge
    import msr_rest_pkg::*;
(
    input  ret_kind_e         kind,
    input  logic [XLEN-1:0]   cur,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   nxt
);
    logic is_n, is_h, is_v, live, src49, old3;

    assign is_n  = (kind == RK_NORMAL);
    assign is_h  = (kind == RK_HYPER);
    assign is_v  = (kind == RK_VECTOR);
    assign live  = is_n | is_h | is_v;
    assign src49 = src[be(49)];
    assign old3  = cur[be(3)];

    always_comb begin
        nxt = cur;
        if (live) begin
            for (int k = 0; k < XLEN; k++) begin
                if (k == 32 || (k >= 37 && k <= 41) || k >= 60) begin
                    nxt[be(k)] = src[be(k)];
                end else if (k <= 28 && k != 3) begin
                    nxt[be(k)] = src[be(k)];
                end else if (k == 3) begin
                    nxt[be(k)] = is_h ? src[be(k)] : (is_n ? (old3 & src[be(k)]) : cur[be(k)]);
                end else if (k >= 49 && k <= 57 && k != 51) begin
                    nxt[be(k)] = src[be(k)];
                end else if (k == 51) begin
                    nxt[be(k)] = (is_h || (is_n && old3)) ? src[be(k)] : cur[be(k)];
                end else if (k == 48 || k == 58 || k == 59) begin
                    nxt[be(k)] = is_v ? src49 : (src[be(k)] | src49);
                end
            end
            if (cur[TF_HI:TF_LO] != 3'b010 || src[TF_HI:TF_LO] != 3'b000) begin
                nxt[TF_HI:TF_LO] = src[TF_HI:TF_LO];
            end
        end
    end
endmodule

// File: rtl/msr_restore_unit.sv
module msr_restore_unit
    import msr_rest_pkg::*;
#(
    parameter logic [63:0] RESET_MSR = 64'h9000_0000_0000_1001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit_i,
    input  logic [1:0]  kind_i,
    input  logic [63:0] srr0_i,
    input  logic [63:0] srr1_i,
    input  logic [63:0] hsrr0_i,
    input  logic [63:0] hsrr1_i,
    input  logic [63:0] ctr_i,
    input  logic [63:0] lr_i,
    output logic [63:0] msr_o,
    output logic [63:0] nia_o,
    output logic        nia_valid_o
);
    ret_kind_e       kind;
    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] state_src, addr_src, merged;
    logic [XLEN-1:0] msr_q, nia_q;
    logic            take;

    assign kind = ret_kind_e'(kind_i);
    assign take = commit_i && (kind != RK_NONE);

    msr_src_select u_sel (
        .kind(kind), .srr0(srr0_i), .srr1(srr1_i), .hsrr0(hsrr0_i),
        .hsrr1(hsrr1_i), .ctr(ctr_i), .lr(lr_i),
        .state_src(state_src), .addr_src(addr_src)
    );

    msr_field_merge u_merge (
        .kind(kind), .cur(msr_q), .src(state_src), .nxt(merged)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = take ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = take ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q <= RESET_MSR;
            nia_q <= '0;
        end else if (take) begin
            msr_q <= merged;
            nia_q <= {addr_src[XLEN-1:2], 2'b00};
        end
    end

    // outputs
    always_comb begin
        msr_o       = msr_q;
        nia_o       = nia_q;
        nia_valid_o = (state_q == ST_ISSUE);
    end

    p_pulse_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> nia_valid_o);
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(msr_o) && !nia_valid_o));
    p_code3_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && kind_i == 2'd3) |=> ($stable(msr_o) && !nia_valid_o));
    p_guard_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && msr_q[TF_HI:TF_LO] == 3'b010 && state_src[TF_HI:TF_LO] == 3'b000)
        |=> (msr_o[TF_HI:TF_LO] == 3'b010));
    p_or_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind != RK_VECTOR && state_src[be(49)])
        |=> (msr_o[be(48)] && msr_o[be(58)] && msr_o[be(59)]));
    p_vec_copy49_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == RK_VECTOR)
        |=> (msr_o[be(48)] == msr_o[be(49)] && msr_o[be(58)] == msr_o[be(49)]
             && msr_o[be(59)] == msr_o[be(49)]));
    p_bit3_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == RK_NORMAL && !msr_q[be(3)])
        |=> (!msr_o[be(3)] && $stable(msr_o[be(51)])));
    p_unnamed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> ($stable(msr_o[be(33):be(36)]) && $stable(msr_o[be(42):be(47)])));
    p_addr_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (nia_o[1:0] == 2'b00 && nia_o[XLEN-1:2] == $past(addr_src[XLEN-1:2])));
endmodule

// File: tb/test_msr_restore_unit.sv
`timescale 1ns/1ps
module test_msr_restore_unit;
    localparam logic [63:0] RST = 64'h9000_0000_0000_1001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_i = 1'b0;
    logic [1:0]  kind_i = 2'd0;
    logic [63:0] srr0_i = '0, srr1_i = '0, hsrr0_i = '0, hsrr1_i = '0, ctr_i = '0, lr_i = '0;
    logic [63:0] msr_o, nia_o;
    logic        nia_valid_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] exp_msr;
    logic [63:0] exp_nia;

    always #2.5 clk = ~clk;

    msr_restore_unit #(.RESET_MSR(RST)) i_msr_restore_unit (
        .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .kind_i(kind_i),
        .srr0_i(srr0_i), .srr1_i(srr1_i), .hsrr0_i(hsrr0_i), .hsrr1_i(hsrr1_i),
        .ctr_i(ctr_i), .lr_i(lr_i), .msr_o(msr_o), .nia_o(nia_o),
        .nia_valid_o(nia_valid_o)
    );

    function automatic logic [63:0] span(input int a, input int b);
        logic [63:0] m = '0;
        for (int k = a; k <= b; k++) m[63-k] = 1'b1;
        return m;
    endfunction

    function automatic logic gb(input logic [63:0] v, input int k);
        return v[63-k];
    endfunction

    function automatic logic [63:0] sb(input logic [63:0] v, input int k, input logic x);
        logic [63:0] r = v;
        r[63-k] = x;
        return r;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] cur, input int kind, input logic [63:0] s);
        logic [63:0] n, cm;
        logic s49;
        if (kind == 3) return cur;
        cm = span(32, 32) | span(37, 41) | span(60, 63);
        if (kind == 1) cm = cm | span(0, 28) | span(49, 57);
        else           cm = cm | span(0, 2) | span(4, 28) | span(49, 50) | span(52, 57);
        n = (cur & ~cm) | (s & cm);
        s49 = gb(s, 49);
        n = sb(n, 48, (kind == 2) ? s49 : (gb(s, 48) | s49));
        n = sb(n, 58, (kind == 2) ? s49 : (gb(s, 58) | s49));
        n = sb(n, 59, (kind == 2) ? s49 : (gb(s, 59) | s49));
        if (kind == 0) begin
            n = sb(n, 3, gb(cur, 3) & gb(s, 3));
            n = sb(n, 51, gb(cur, 3) ? gb(s, 51) : gb(cur, 51));
        end
        if (cur[34:32] != 3'b010 || s[34:32] != 3'b000) n[34:32] = s[34:32];
        return n;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one commit and check the cycle after it
    task automatic issue(input int kind, input logic [63:0] s0, input logic [63:0] s1,
                         input string tag);
        logic [63:0] prev_nia;
        prev_nia = exp_nia;
        @(negedge clk);
        commit_i = 1'b1;
        kind_i = kind[1:0];
        srr0_i = '0; srr1_i = '0; hsrr0_i = '0; hsrr1_i = '0; ctr_i = '0; lr_i = '0;
        case (kind)
            0: begin srr0_i = s0;  srr1_i = s1;  end
            1: begin hsrr0_i = s0; hsrr1_i = s1; end
            2: begin lr_i = s0;    ctr_i = s1;   end
            default: begin srr0_i = s0; srr1_i = s1; hsrr0_i = s0; hsrr1_i = s1; ctr_i = s1; lr_i = s0; end
        endcase
        exp_msr = model(exp_msr, kind, s1);
        exp_nia = (kind == 3) ? prev_nia : {s0[63:2], 2'b00};
        @(negedge clk);
        commit_i = 1'b0;
        chk({tag, " state"}, msr_o, exp_msr);
        chk("R2 R3 valid", {63'd0, nia_valid_o}, {63'd0, kind != 3});
        if (kind != 3) chk("R11 address", nia_o, exp_nia);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R2 idle valid", {63'd0, nia_valid_o}, 64'd0);
        chk("R2 idle state", msr_o, exp_msr);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240611));
        exp_msr = RST;
        exp_nia = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", msr_o, RST);
        chk("R1 reset valid", {63'd0, nia_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after release", msr_o, RST);

        // R8: hypervisor load: bit3=1, bit51=1, guarded field 010, bit49=0
        v = 64'h0123_4567_89AB_CDEF;
        v = sb(v, 3, 1'b1); v = sb(v, 51, 1'b1); v = sb(v, 49, 1'b0);
        v[34:32] = 3'b010;
        issue(1, 64'hFFFF_0000_1234_5677, v, "R8 hyper copy");
        chk("R4 field loaded", {61'd0, msr_o[34:32]}, 64'd2);

        // R4: guard keeps 010 against source 000
        v = 64'hAAAA_5555_0F0F_F0F0; v[34:32] = 3'b000; v = sb(v, 3, 1'b0); v = sb(v, 51, 1'b0);
        issue(0, 64'h0000_0000_0000_1003, v, "R4 R7 normal");
        chk("R4 guard holds", {61'd0, msr_o[34:32]}, 64'd2);
        chk("R7 bit3 cleared", {63'd0, gb(msr_o, 3)}, 64'd0);
        chk("R7 bit51 from source", {63'd0, gb(msr_o, 51)}, 64'd0);

        // R7: old bit3 clear: bit3 stays 0, bit51 keeps
        v = sb(v, 3, 1'b1); v = sb(v, 51, 1'b1); v[34:32] = 3'b101;
        issue(0, 64'h7, v, "R7 normal keep");
        chk("R7 bit3 sticky", {63'd0, gb(msr_o, 3)}, 64'd0);
        chk("R7 bit51 kept", {63'd0, gb(msr_o, 51)}, 64'd0);
        chk("R4 field replaced", {61'd0, msr_o[34:32]}, 64'd5);

        // R6: vectored, src48=1, src49=0
        v = 64'hFFFF_FFFF_FFFF_FFFF; v = sb(v, 49, 1'b0);
        issue(2, 64'hDEAD_BEEF_CAFE_F00D, v, "R6 R9 vectored");
        chk("R6 bit48", {63'd0, gb(msr_o, 48)}, 64'd0);
        chk("R6 bit58", {63'd0, gb(msr_o, 58)}, 64'd0);

        // R5: normal, src48=0 src49=1
        v = 64'd0; v = sb(v, 49, 1'b1);
        issue(0, 64'h10, v, "R5 R8 normal");
        chk("R5 fold", {61'd0, gb(msr_o, 48), gb(msr_o, 58), gb(msr_o, 59)}, 64'd7);

        // R3: code 3 ignored
        issue(3, 64'h1111_1111_1111_1111, 64'hFFFF_FFFF_FFFF_FFFF, "R3 ignored");
        idle_check();
        chk("R10 untouched bits", msr_o & (span(33, 36) | span(42, 47)),
            RST & (span(33, 36) | span(42, 47)));

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [63:0] a, s;
            k = $urandom_range(0, 3);
            a = {$urandom, $urandom};
            s = {$urandom, $urandom};
            if ($urandom_range(0, 2) == 0) s[34:32] = 3'b000;
            if ($urandom_range(0, 3) == 0) s[34:32] = 3'b010;
            issue(k, a, s, "R4 R5 R6 R7 R8 R9 random");
            if ($urandom_range(0, 3) == 0) idle_check();
        end
        chk("R10 untouched bits end", msr_o & (span(33, 36) | span(42, 47)),
            RST & (span(33, 36) | span(42, 47)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule